// File: doc/BRIEF.md
# Three-Phase Sample Rate Sequencer

This block paces a transient capture. It issues one-cycle scan-start pulses, and each pulse asks the acquisition path to sample and convert every selected channel once. A capture runs in three phases. In the pre-trigger phase the block samples at the pre-trigger rate until a trigger arrives. The near phase then samples at its own rate for a programmed number of scans. The far phase follows at a third rate for a second programmed number of scans. When the far count is used up, the block reports end of event and returns to the pre-trigger phase.

Each phase picks its rate with a 5-bit code that divides a base tick by a power of two. The base tick comes from an internal reference or from an external clock, chosen by a select input. The two post-trigger sample counts are given as one's complements. They are copied into counters at the trigger, and each counter ends its phase when it reaches all ones. Arm, inhibit-pre-trigger (single-scan use), continuous and a memory-full flag decide when scanning may run.

The state machine has three states:
- `PH_PRE` (phase 0).
- `PH_NEAR` (phase 1), entered from `PH_PRE` on an armed trigger.
- `PH_FAR` (phase 2), entered from `PH_NEAR` when the near counter is exhausted.

`PH_FAR` returns to `PH_PRE` when the far counter is exhausted, with `end_of_event` raised in that last far cycle.

Top module: `rate_phase_seq`

## Requirements
- R1: After reset `phase` is 0 (pre-trigger), and `busy`, `scan_start` and `end_of_event` are 0.
- R2: With `ext_sel`=0 the divisor of `int_tick` is 2^(code-2). Codes 0, 1 and 2 give one scan per tick, and each code above 2 halves the rate again.
- R3: With `ext_sel`=1 only `ext_tick` counts, and the divisor is 2^code: code 0 gives the full external rate and code 1 gives half of it.
- R4: In phase 0 no scan is issued while `arm` is 0, and a trigger is accepted only while `arm` is 1.
- R5: While `inhibit_pre` is 1, no scan is issued in phase 0. The post-trigger phases still scan at their own rates.
- R6: While `full_flag` is 1 and `continuous` is 0, no scan is issued in any phase. With `continuous` at 1 the full flag has no effect.
- R7: The near phase issues exactly ~`near_cnt_n` scans and the far phase issues exactly ~`far_cnt_n` scans (16-bit one's complement). The value 16'hFFFF means zero scans.
- R8: An armed trigger in phase 0 moves to phase 1 (near). An exhausted near count moves to phase 2 (far). An exhausted far count moves back to phase 0. `end_of_event` is a one-cycle pulse in the last far cycle, and `busy` is 1 in phases 1 and 2.
- R9: A phase with a zero count lasts one clock. With both counts zero, `end_of_event` is high in the second cycle after the trigger cycle.
- R10: The rate divider restarts on every phase change, so the first scan of a new phase comes exactly one full period of the new rate after the change.
- R11: Outside phase 0 a trigger is ignored. The counts are captured at the accepted trigger, so later changes to the count inputs do not alter the running event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| int_tick | input | 1 | Internal base tick, one cycle wide, at the code-2 rate |
| ext_tick | input | 1 | External base tick, one cycle wide |
| ext_sel | input | 1 | 1 selects the external tick and external code mapping |
| arm | input | 1 | Enables pre-trigger scanning and trigger acceptance |
| inhibit_pre | input | 1 | Blocks scanning in phase 0 (single-scan use) |
| continuous | input | 1 | Makes the full flag ignored |
| full_flag | input | 1 | Memory full; halts scanning unless continuous |
| trigger | input | 1 | Trigger request |
| pre_code | input | 5 | Rate code for phase 0 |
| near_code | input | 5 | Rate code for phase 1 |
| far_code | input | 5 | Rate code for phase 2 |
| near_cnt_n | input | 16 | One's complement of the near scan count |
| far_cnt_n | input | 16 | One's complement of the far scan count |
| scan_start | output | 1 | One-cycle scan request |
| phase | output | 2 | Current phase: 0 pre, 1 near, 2 far |
| busy | output | 1 | High in phases 1 and 2 |
| end_of_event | output | 1 | Pulse in the last far-phase cycle |

## Verification
A pre-trigger scan and an accepted trigger can fall in the same cycle. The bench provokes this by running phase 0 at one scan per tick and raising the trigger. It then expects `scan_start` high in the trigger cycle and exactly the programmed near scans afterwards, with none lost or doubled. A retrigger can also coincide with a running near phase. The bench pulses the trigger and rewrites both count inputs mid-event, then judges the event by unchanged scan counts and an unchanged end-of-event cycle.

// File: rtl/rps_pkg.sv
package rps_pkg;
    typedef enum logic [1:0] {
        PH_PRE  = 2'd0,
        PH_NEAR = 2'd1,
        PH_FAR  = 2'd2
    } phase_e;
endpackage

// File: rtl/rps_rate_div.sv
module rps_rate_div #(
    parameter int CODE_W     = 5,
    parameter int DIV_W      = 32,
    parameter int INT_OFFSET = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              run,
    input  logic              tick,
    input  logic              ext_mode,
    input  logic [CODE_W-1:0] code,
    output logic              fire
);
    localparam logic [CODE_W-1:0] OFFS = CODE_W'(INT_OFFSET);

    logic [CODE_W-1:0] shift;
    logic [DIV_W-1:0]  div_m1;
    logic [DIV_W-1:0]  cnt_q;

    always_comb begin
        if (ext_mode)
            shift = code;
        else if (code < OFFS)
            shift = '0;
        else
            shift = code - OFFS;
        div_m1 = (DIV_W'(1) << shift) - DIV_W'(1);
        fire   = run && tick && (cnt_q >= div_m1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (run && tick)
            cnt_q <= fire ? '0 : cnt_q + DIV_W'(1);
    end
endmodule

// File: rtl/rps_post_cnt.sv
module rps_post_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    assign done = &cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '1;
        else if (load)
            cnt_q <= load_val;
        else if (step && !done)
            cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/rate_phase_seq.sv
module rate_phase_seq #(
    parameter int CODE_W     = 5,
    parameter int CNT_W      = 16,
    parameter int DIV_W      = 32,
    parameter int INT_OFFSET = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              int_tick,
    input  logic              ext_tick,
    input  logic              ext_sel,
    input  logic              arm,
    input  logic              inhibit_pre,
    input  logic              continuous,
    input  logic              full_flag,
    input  logic              trigger,
    input  logic [CODE_W-1:0] pre_code,
    input  logic [CODE_W-1:0] near_code,
    input  logic [CODE_W-1:0] far_code,
    input  logic [CNT_W-1:0]  near_cnt_n,
    input  logic [CNT_W-1:0]  far_cnt_n,
    output logic              scan_start,
    output logic [1:0]        phase,
    output logic              busy,
    output logic              end_of_event
);
    import rps_pkg::*;

    localparam int NPOST = 2;

    phase_e state_q, state_d;

    logic                        fill_ok;
    logic                        run;
    logic                        div_clr;
    logic                        tick_sel;
    logic                        fire;
    logic [CODE_W-1:0]           code_sel;
    logic                        load_cnt;
    logic [NPOST-1:0]            post_done;
    logic [NPOST-1:0]            post_step;
    logic [NPOST-1:0][CNT_W-1:0] post_init;

    assign fill_ok   = continuous || !full_flag;
    assign tick_sel  = ext_sel ? ext_tick : int_tick;
    assign post_init = {far_cnt_n, near_cnt_n};

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= PH_PRE;
        else
            state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_PRE:  if (trigger && arm) state_d = PH_NEAR;
            PH_NEAR: if (post_done[0])   state_d = PH_FAR;
            PH_FAR:  if (post_done[1])   state_d = PH_PRE;
            default: state_d = PH_PRE;
        endcase
    end

    // outputs and per-phase controls
    always_comb begin
        run          = 1'b0;
        code_sel     = pre_code;
        busy         = 1'b0;
        end_of_event = 1'b0;
        unique case (state_q)
            PH_PRE: begin
                run      = arm && !inhibit_pre && fill_ok;
                code_sel = pre_code;
            end
            PH_NEAR: begin
                run      = !post_done[0] && fill_ok;
                code_sel = near_code;
                busy     = 1'b1;
            end
            PH_FAR: begin
                run          = !post_done[1] && fill_ok;
                code_sel     = far_code;
                busy         = 1'b1;
                end_of_event = post_done[1];
            end
            default: begin
                run = 1'b0;
            end
        endcase
        phase      = state_q;
        scan_start = fire;
        load_cnt   = (state_q == PH_PRE) && (state_d == PH_NEAR);
        div_clr    = (state_d != state_q) || !run;
    end

    rps_rate_div #(
        .CODE_W    (CODE_W),
        .DIV_W     (DIV_W),
        .INT_OFFSET(INT_OFFSET)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (div_clr),
        .run     (run),
        .tick    (tick_sel),
        .ext_mode(ext_sel),
        .code    (code_sel),
        .fire    (fire)
    );

    for (genvar g = 0; g < NPOST; g++) begin : g_post
        assign post_step[g] = fire && (state_q == phase_e'(g + 1));
        rps_post_cnt #(.CNT_W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (load_cnt),
            .load_val(post_init[g]),
            .step    (post_step[g]),
            .done    (post_done[g])
        );
    end
endmodule

// File: rtl/rate_phase_seq_chk.sv
module rate_phase_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       arm,
    input logic       inhibit_pre,
    input logic       continuous,
    input logic       full_flag,
    input logic       trigger,
    input logic       scan_start,
    input logic [1:0] phase,
    input logic       busy,
    input logic       end_of_event
);
    a_r4_no_scan_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd0 && !arm) |-> !scan_start);

    a_r5_inhibit_pre: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd0 && inhibit_pre) |-> !scan_start);

    a_r6_full_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (full_flag && !continuous) |-> !scan_start);

    a_r8_eoe_returns: assert property (@(posedge clk) disable iff (!rst_n)
        end_of_event |=> (phase == 2'd0 && !busy));

    a_r8_eoe_in_far: assert property (@(posedge clk) disable iff (!rst_n)
        end_of_event |-> (phase == 2'd2));

    a_r8_near_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd1 && $past(phase) == 2'd0) |-> $past(trigger && arm));

    a_r11_no_phase_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd2) |=> (phase == 2'd2 || phase == 2'd0));
endmodule

bind rate_phase_seq rate_phase_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm         (arm),
    .inhibit_pre (inhibit_pre),
    .continuous  (continuous),
    .full_flag   (full_flag),
    .trigger     (trigger),
    .scan_start  (scan_start),
    .phase       (phase),
    .busy        (busy),
    .end_of_event(end_of_event)
);

// File: tb/rate_phase_seq_test.sv
module rate_phase_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        int_tick = 1'b1, ext_tick = 1'b1, ext_sel = 1'b0;
    logic        arm = 1'b0, inhibit_pre = 1'b1, continuous = 1'b0;
    logic        full_flag = 1'b0, trigger = 1'b0;
    logic [4:0]  pre_code = 5'd2, near_code = 5'd2, far_code = 5'd2;
    logic [15:0] near_cnt_n = 16'hFFFF, far_cnt_n = 16'hFFFF;
    logic        scan_start, busy, end_of_event;
    logic [1:0]  phase;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    int got_near, got_far, got_eoe, got_first, got_trigscan;

    always #4 clk = ~clk;

    rate_phase_seq uut (
        .clk(clk), .rst_n(rst_n), .int_tick(int_tick), .ext_tick(ext_tick),
        .ext_sel(ext_sel), .arm(arm), .inhibit_pre(inhibit_pre),
        .continuous(continuous), .full_flag(full_flag), .trigger(trigger),
        .pre_code(pre_code), .near_code(near_code), .far_code(far_code),
        .near_cnt_n(near_cnt_n), .far_cnt_n(far_cnt_n),
        .scan_start(scan_start), .phase(phase), .busy(busy),
        .end_of_event(end_of_event)
    );

    typedef struct packed {
        logic       ext;
        logic [4:0] nc;
        logic [4:0] fc;
        logic [7:0] n;
        logic [7:0] f;
        logic [7:0] eoe;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{1'b0, 5'd2, 5'd2, 8'd3, 8'd2, 8'd7},
        '{1'b0, 5'd3, 5'd4, 8'd2, 8'd1, 8'd10},
        '{1'b0, 5'd0, 5'd5, 8'd0, 8'd2, 8'd18},
        '{1'b1, 5'd1, 5'd0, 8'd4, 8'd0, 8'd10},
        '{1'b1, 5'd3, 5'd2, 8'd1, 8'd3, 8'd22},
        '{1'b0, 5'd6, 5'd6, 8'd0, 8'd0, 8'd2},
        '{1'b0, 5'd6, 5'd3, 8'd2, 8'd1, 8'd36}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic count_scans(input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk); #1;
            if (scan_start) n++;
        end
    endtask

    task automatic run_event(input bit ext, input logic [4:0] nc, input logic [4:0] fc,
                             input int n, input int f, input bit retrig);
        bit fin;
        fin = 0;
        got_near = 0; got_far = 0; got_eoe = -1; got_first = -1;
        @(negedge clk);
        ext_sel = ext; near_code = nc; far_code = fc;
        near_cnt_n = ~16'(n); far_cnt_n = ~16'(f); trigger = 1'b1;
        #1 got_trigscan = int'(scan_start);
        @(negedge clk);
        trigger = 1'b0;
        for (int k = 1; k <= 300 && !fin; k++) begin
            #1;
            if (phase == 2'd1 && scan_start) begin
                got_near++;
                if (got_first < 0) got_first = k;
            end
            if (phase == 2'd2 && scan_start) got_far++;
            if (end_of_event && got_eoe < 0) got_eoe = k;
            if (phase == 2'd0 && k > 1) fin = 1;
            if (retrig && k == 5) begin
                trigger = 1'b1; near_cnt_n = 16'h0000; far_cnt_n = 16'h0000;
            end
            if (retrig && k == 6) trigger = 1'b0;
            if (!fin) @(negedge clk);
        end
        ext_sel = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        check("R1 phase", int'(phase), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 scan", int'(scan_start), 0);
        check("R1 eoe", int'(end_of_event), 0);
        @(negedge clk); rst_n = 1'b1;

        // vector table: R7 R8 R9 R2 R3
        arm = 1'b1; inhibit_pre = 1'b1;
        foreach (VECS[i]) begin
            run_event(VECS[i].ext, VECS[i].nc, VECS[i].fc, int'(VECS[i].n), int'(VECS[i].f), 1'b0);
            check($sformatf("R7 near count vec%0d", i), got_near, int'(VECS[i].n));
            check($sformatf("R7 far count vec%0d", i), got_far, int'(VECS[i].f));
            check($sformatf("R8 R9 eoe cycle vec%0d", i), got_eoe, int'(VECS[i].eoe));
        end

        // R2: internal code 3 divides by 2
        @(negedge clk); pre_code = 5'd3; inhibit_pre = 1'b0;
        count_scans(20, n); check("R2 pre code3", n, 10);
        // R5: inhibit blocks phase 0
        inhibit_pre = 1'b1;
        count_scans(20, n); check("R5 inhibit", n, 0);
        // R4: unarmed gives no scan, trigger ignored
        inhibit_pre = 1'b0; arm = 1'b0; trigger = 1'b1;
        count_scans(20, n); check("R4 unarmed scans", n, 0);
        check("R4 trigger ignored", int'(phase), 0);
        trigger = 1'b0; arm = 1'b1;
        // R6: full halts, continuous overrides
        full_flag = 1'b1;
        count_scans(20, n); check("R6 full halts", n, 0);
        continuous = 1'b1;
        count_scans(20, n); check("R6 continuous", n, 10);
        full_flag = 1'b0; continuous = 1'b0;
        // R3: external select uses only ext_tick
        arm = 1'b0; ext_sel = 1'b1; ext_tick = 1'b0; pre_code = 5'd0;
        @(negedge clk); arm = 1'b1;
        count_scans(20, n); check("R3 ext tick only", n, 0);
        arm = 1'b0; ext_tick = 1'b1; pre_code = 5'd2;
        @(negedge clk); arm = 1'b1;
        count_scans(20, n); check("R3 ext code2", n, 5);
        ext_sel = 1'b0;

        // R10: divider restarts at trigger (pre div4, trigger mid-period)
        pre_code = 5'd4;
        n = 0;
        for (int i = 0; i < 20 && n == 0; i++) begin
            @(negedge clk); #1;
            if (scan_start) n = 1;
        end
        @(negedge clk); @(negedge clk);
        run_event(1'b0, 5'd4, 5'd2, 1, 0, 1'b0);
        check("R10 first near scan", got_first, 4);
        check("R10 eoe", got_eoe, 6);

        // same cycle: pre scan and trigger
        pre_code = 5'd2;
        run_event(1'b0, 5'd2, 5'd2, 2, 0, 1'b0);
        check("R8 scan in trigger cycle", got_trigscan, 1);
        check("R7 near after same-cycle trigger", got_near, 2);
        check("R8 eoe after same-cycle trigger", got_eoe, 4);

        // R11: retrigger and count change mid-event ignored
        inhibit_pre = 1'b1;
        run_event(1'b0, 5'd6, 5'd3, 2, 1, 1'b1);
        check("R11 near", got_near, 2);
        check("R11 far", got_far, 1);
        check("R11 eoe", got_eoe, 36);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule